// File: doc/BRIEF.md
# Low-Power Wake Event Detector

This block watches for wake requests while a bus transceiver sits in one of its low-power states. It has two sources. The first is a synchronized local wake pin. The second is the output of a low-power bus receiver that reports dominant or recessive. When either source shows a qualified wake event, a sticky wake flag is raised for the mode controller. A separate sticky flag records that the wake came from the local pin. The block also drives a pull-direction select for the wake pin, which follows the last filtered pin level.

A bus wake needs a three-part pattern: dominant, then recessive, then dominant. Each part must be held for a minimum number of timebase ticks, and the whole pattern must finish inside a timeout window. A local wake is a pin level that differs from the last accepted level and stays there for a filter time. Shorter excursions and bounces restart the filter. All filtering advances only on a timebase tick, so the time constants scale with the tick rate.

The mode controller supplies three things: a detection-enable level that is high in the low-power states, and clear strobes for entering Normal, leaving Normal and supply undervoltage. After reset, local detection stays off for a startup delay.

Top module: `wake_detector`

## Requirements
- R1: With `lp_active` high, `bus_dom` held high for at least PHASE_TICKS ticks, then low for at least PHASE_TICKS ticks, then high for PHASE_TICKS ticks sets `wake_flag`. `bus_dom` = 1 means dominant.
- R2: A dominant or recessive phase shorter than PHASE_TICKS ticks restarts the count of that phase. Such a phase sets no flag.
- R3: The timeout window opens when the first dominant phase qualifies. If the pattern has not completed after TIMEOUT_TICKS ticks, the detector returns to idle and sets no flag.
- R4: A local wake occurs when `wake_pin` differs from the last accepted level for LOC_FILT_TICKS consecutive ticks. The new level then becomes the accepted level. A local wake sets `wake_flag` and `local_src`. A level that returns earlier restarts the filter.
- R5: `pull_up_sel` is 1 (pull-up) after reset. It then equals the last accepted wake-pin level: 1 after a filtered high and 0 after a filtered low.
- R6: While `lp_active` is low, no wake of either kind is flagged, and the bus pattern detector is held idle. The pull select still tracks the pin.
- R7: `wake_flag` is cleared one cycle after `clr_nrm_entry` or `uv_detect` is high. A clear overrides a wake that arrives in the same cycle.
- R8: `local_src` is set only by a local wake and is cleared one cycle after `clr_nrm_exit`. The wake-flag clears do not affect it.
- R9: For STARTUP_TICKS ticks after reset, local wakes are ignored, while the pull select still follows the pin.
- R10: The filters and counters advance only in cycles where `tick` is high.
- R11: After reset, `wake_flag` = 0, `local_src` = 0 and `pull_up_sel` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| tick | input | 1 | Filter timebase strobe |
| lp_active | input | 1 | High in Standby, Go-to-sleep and Sleep |
| wake_pin | input | 1 | Synchronized local wake pin level |
| bus_dom | input | 1 | Low-power bus receiver, 1 = dominant |
| clr_nrm_entry | input | 1 | Strobe: Normal mode entered |
| clr_nrm_exit | input | 1 | Strobe: Normal mode left |
| uv_detect | input | 1 | Strobe: supply undervoltage detected |
| wake_flag | output | 1 | Sticky wake flag |
| local_src | output | 1 | Sticky flag: wake came from the local pin |
| pull_up_sel | output | 1 | Wake pin pull select, 1 = pull-up, 0 = pull-down |

## Verification
The bus detector is driven with a full pattern at the minimum phase length and with stretched phases, which must both wake. It is also driven with patterns where one phase is a single tick short, and where the recessive gap overruns the timeout; these separate correct phase counting from plain edge detection. The local pin is driven with pulses one tick short of and exactly at the filter time, and with a bounce that splits a long low into two short ones, so that a restarting filter can be told apart from an accumulating one. Directed cases cover the startup blackout, disabled detection, a clear that collides with a wake, and a held-off timebase.

// File: rtl/wkd_pkg.sv
package wkd_pkg;
  typedef enum logic [1:0] {
    BUS_IDLE   = 2'd0,
    BUS_DOM_OK = 2'd1,
    BUS_REC_OK = 2'd2
  } bus_state_t;
endpackage

// File: rtl/wkd_bus_pattern.sv
module wkd_bus_pattern #(
  parameter int PHASE_TICKS   = 4,
  parameter int TIMEOUT_TICKS = 30
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic lp_active,
  input  logic bus_dom,
  output logic bus_wake
);
  import wkd_pkg::*;

  localparam int PW = $clog2(PHASE_TICKS + 1);
  localparam int TW = $clog2(TIMEOUT_TICKS + 1);
  localparam logic [PW-1:0] PH_LAST = PW'(PHASE_TICKS - 1);
  localparam logic [TW-1:0] TO_LAST = TW'(TIMEOUT_TICKS - 1);

  bus_state_t    state;
  logic [PW-1:0] ph_cnt;
  logic [TW-1:0] to_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= BUS_IDLE;
      ph_cnt   <= '0;
      to_cnt   <= '0;
      bus_wake <= 1'b0;
    end else begin
      bus_wake <= 1'b0;
      if (!lp_active) begin
        state  <= BUS_IDLE;
        ph_cnt <= '0;
        to_cnt <= '0;
      end else if (tick) begin
        case (state)
          BUS_IDLE: begin
            to_cnt <= '0;
            if (bus_dom) begin
              if (ph_cnt == PH_LAST) begin
                state  <= BUS_DOM_OK;
                ph_cnt <= '0;
              end else begin
                ph_cnt <= ph_cnt + 1'b1;
              end
            end else begin
              ph_cnt <= '0;
            end
          end
          BUS_DOM_OK: begin
            if (to_cnt == TO_LAST) begin
              state  <= BUS_IDLE;
              ph_cnt <= '0;
              to_cnt <= '0;
            end else begin
              to_cnt <= to_cnt + 1'b1;
              if (!bus_dom) begin
                if (ph_cnt == PH_LAST) begin
                  state  <= BUS_REC_OK;
                  ph_cnt <= '0;
                end else begin
                  ph_cnt <= ph_cnt + 1'b1;
                end
              end else begin
                ph_cnt <= '0;
              end
            end
          end
          BUS_REC_OK: begin
            if (bus_dom && ph_cnt == PH_LAST) begin
              bus_wake <= 1'b1;
              state    <= BUS_IDLE;
              ph_cnt   <= '0;
              to_cnt   <= '0;
            end else if (to_cnt == TO_LAST) begin
              state  <= BUS_IDLE;
              ph_cnt <= '0;
              to_cnt <= '0;
            end else begin
              to_cnt <= to_cnt + 1'b1;
              ph_cnt <= bus_dom ? ph_cnt + 1'b1 : '0;
            end
          end
          default: begin
            state  <= BUS_IDLE;
            ph_cnt <= '0;
            to_cnt <= '0;
          end
        endcase
      end
    end
  end

  AST_BUS_INACTIVE_NO_WAKE: assert property (@(posedge clk) disable iff (rst)
    !lp_active |=> !bus_wake);  // R6
  AST_TO_BOUND: assert property (@(posedge clk) disable iff (rst)
    to_cnt <= TO_LAST);  // R3
  AST_IDLE_NO_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (state == BUS_IDLE) |-> (to_cnt == '0));  // R3
  AST_BUS_WAKE_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
    !tick |=> !bus_wake);  // R10
endmodule

// File: rtl/wkd_local_filter.sv
module wkd_local_filter #(
  parameter int FILT_TICKS    = 5,
  parameter int STARTUP_TICKS = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic lp_active,
  input  logic wake_pin,
  output logic loc_wake,
  output logic pull_up
);
  localparam int FW = $clog2(FILT_TICKS + 1);
  localparam int SW = $clog2(STARTUP_TICKS + 1);
  localparam logic [FW-1:0] F_LAST = FW'(FILT_TICKS - 1);
  localparam logic [SW-1:0] S_DONE = SW'(STARTUP_TICKS);

  logic [FW-1:0] flt_cnt;
  logic [SW-1:0] su_cnt;
  logic          det_en;

  assign det_en = (su_cnt == S_DONE) && lp_active;

  always_ff @(posedge clk) begin
    if (rst) begin
      su_cnt <= '0;
    end else if (tick && su_cnt != S_DONE) begin
      su_cnt <= su_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pull_up  <= 1'b1;
      flt_cnt  <= '0;
      loc_wake <= 1'b0;
    end else begin
      loc_wake <= 1'b0;
      if (tick) begin
        if (wake_pin != pull_up) begin
          if (flt_cnt == F_LAST) begin
            pull_up  <= wake_pin;
            flt_cnt  <= '0;
            loc_wake <= det_en;
          end else begin
            flt_cnt <= flt_cnt + 1'b1;
          end
        end else begin
          flt_cnt <= '0;
        end
      end
    end
  end

  AST_NO_LOCAL_IN_STARTUP: assert property (@(posedge clk) disable iff (rst)
    (su_cnt != S_DONE) |=> !loc_wake);  // R9
  AST_PULL_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(pull_up));  // R10
  AST_WAKE_FOLLOWS_PULL_CHANGE: assert property (@(posedge clk) disable iff (rst)
    loc_wake |-> !$stable(pull_up));  // R4
  AST_LOCAL_INACTIVE: assert property (@(posedge clk) disable iff (rst)
    !lp_active |=> !loc_wake);  // R6
endmodule

// File: rtl/wkd_flags.sv
module wkd_flags (
  input  logic clk,
  input  logic rst,
  input  logic bus_wake,
  input  logic loc_wake,
  input  logic clr_nrm_entry,
  input  logic clr_nrm_exit,
  input  logic uv_detect,
  output logic wake_flag,
  output logic local_src
);
  always_ff @(posedge clk) begin
    if (rst) begin
      wake_flag <= 1'b0;
      local_src <= 1'b0;
    end else begin
      if (clr_nrm_entry || uv_detect) wake_flag <= 1'b0;
      else if (bus_wake || loc_wake)  wake_flag <= 1'b1;
      if (clr_nrm_exit)  local_src <= 1'b0;
      else if (loc_wake) local_src <= 1'b1;
    end
  end

  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (clr_nrm_entry || uv_detect) |=> !wake_flag);  // R7
  AST_SRC_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clr_nrm_exit |=> !local_src);  // R8
  AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(wake_flag) |-> $past(bus_wake || loc_wake));  // R1
  AST_SRC_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(local_src) |-> $past(loc_wake));  // R8
endmodule

// File: rtl/wake_detector.sv
module wake_detector #(
  parameter int PHASE_TICKS    = 4,
  parameter int TIMEOUT_TICKS  = 30,
  parameter int LOC_FILT_TICKS = 5,
  parameter int STARTUP_TICKS  = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic lp_active,
  input  logic wake_pin,
  input  logic bus_dom,
  input  logic clr_nrm_entry,
  input  logic clr_nrm_exit,
  input  logic uv_detect,
  output logic wake_flag,
  output logic local_src,
  output logic pull_up_sel
);
  logic bus_wake;
  logic loc_wake;

  wkd_bus_pattern #(
    .PHASE_TICKS  (PHASE_TICKS),
    .TIMEOUT_TICKS(TIMEOUT_TICKS)
  ) u_bus (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .lp_active(lp_active),
    .bus_dom  (bus_dom),
    .bus_wake (bus_wake)
  );

  wkd_local_filter #(
    .FILT_TICKS   (LOC_FILT_TICKS),
    .STARTUP_TICKS(STARTUP_TICKS)
  ) u_loc (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .lp_active(lp_active),
    .wake_pin (wake_pin),
    .loc_wake (loc_wake),
    .pull_up  (pull_up_sel)
  );

  wkd_flags u_flags (
    .clk          (clk),
    .rst          (rst),
    .bus_wake     (bus_wake),
    .loc_wake     (loc_wake),
    .clr_nrm_entry(clr_nrm_entry),
    .clr_nrm_exit (clr_nrm_exit),
    .uv_detect    (uv_detect),
    .wake_flag    (wake_flag),
    .local_src    (local_src)
  );

  AST_RESET_CLEAN: assert property (@(posedge clk)
    rst |=> (!wake_flag && !local_src && pull_up_sel));  // R11
endmodule

// File: tb/wake_detector_test.sv
module wake_detector_test;
  logic clk = 1'b0;
  logic rst, tick, lp_active, wake_pin, bus_dom;
  logic clr_nrm_entry, clr_nrm_exit, uv_detect;
  logic wake_flag, local_src, pull_up_sel;
  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  wake_detector #(
    .PHASE_TICKS(4), .TIMEOUT_TICKS(30), .LOC_FILT_TICKS(5), .STARTUP_TICKS(20)
  ) uut (
    .clk(clk), .rst(rst), .tick(tick), .lp_active(lp_active),
    .wake_pin(wake_pin), .bus_dom(bus_dom), .clr_nrm_entry(clr_nrm_entry),
    .clr_nrm_exit(clr_nrm_exit), .uv_detect(uv_detect),
    .wake_flag(wake_flag), .local_src(local_src), .pull_up_sel(pull_up_sel)
  );

  typedef struct packed {
    logic       loc;
    logic [7:0] a;
    logic [7:0] b;
    logic [7:0] c;
    logic       ef;
    logic       es;
  } vec_t;

  // bus: dominant a, recessive b, dominant c; local: low a, high b, low c
  localparam vec_t VECS [10] = '{
    '{1'b0, 8'd4,  8'd4,  8'd4, 1'b1, 1'b0},  // R1 minimum phases
    '{1'b0, 8'd3,  8'd4,  8'd4, 1'b0, 1'b0},  // R2 first phase short
    '{1'b0, 8'd4,  8'd3,  8'd4, 1'b0, 1'b0},  // R2 gap short
    '{1'b0, 8'd4,  8'd4,  8'd3, 1'b0, 1'b0},  // R2 last phase short
    '{1'b0, 8'd10, 8'd6,  8'd9, 1'b1, 1'b0},  // R1 stretched phases
    '{1'b0, 8'd4,  8'd35, 8'd4, 1'b0, 1'b0},  // R3 timeout
    '{1'b1, 8'd5,  8'd0,  8'd0, 1'b1, 1'b1},  // R4 exact filter
    '{1'b1, 8'd4,  8'd0,  8'd0, 1'b0, 1'b0},  // R4 one short
    '{1'b1, 8'd3,  8'd1,  8'd3, 1'b0, 1'b0},  // R4 bounce restarts
    '{1'b1, 8'd4,  8'd1,  8'd5, 1'b1, 1'b1}   // R4 bounce then held
  };

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic clear_all();
    lp_active = 1'b0; clr_nrm_entry = 1'b1; clr_nrm_exit = 1'b1;
    cyc(1);
    lp_active = 1'b1; clr_nrm_entry = 1'b0; clr_nrm_exit = 1'b0;
    cyc(1);
  endtask

  task automatic bus_pat(input int a, input int b, input int c);
    bus_dom = 1'b1; cyc(a);
    bus_dom = 1'b0; cyc(b);
    bus_dom = 1'b1; cyc(c);
    bus_dom = 1'b0; cyc(40);
  endtask

  task automatic loc_pat(input int a, input int b, input int c);
    wake_pin = 1'b0; cyc(a);
    wake_pin = 1'b1; cyc(b);
    wake_pin = 1'b0; cyc(c);
    wake_pin = 1'b1; cyc(40);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R10 watchdog: actual=timeout expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; tick = 1'b1; lp_active = 1'b1; wake_pin = 1'b1; bus_dom = 1'b0;
    clr_nrm_entry = 1'b0; clr_nrm_exit = 1'b0; uv_detect = 1'b0;
    cyc(3);
    rst = 1'b0;
    // R11 reset state
    chk("R11 wake_flag", wake_flag, 1'b0);
    chk("R11 local_src", local_src, 1'b0);
    chk("R11 pull_up_sel", pull_up_sel, 1'b1);

    // R9 startup blackout, pull still tracks (R5)
    wake_pin = 1'b0; cyc(6);
    chk("R9 pull low in startup", pull_up_sel, 1'b0);
    wake_pin = 1'b1; cyc(7);
    chk("R9 pull high in startup", pull_up_sel, 1'b1);
    chk("R9 no wake in startup", wake_flag, 1'b0);
    cyc(20);

    for (int i = 0; i < 10; i++) begin
      clear_all();
      if (VECS[i].loc) loc_pat(VECS[i].a, VECS[i].b, VECS[i].c);
      else             bus_pat(VECS[i].a, VECS[i].b, VECS[i].c);
      chk($sformatf("%s vec%0d wake_flag", VECS[i].loc ? "R4" : "R1/R2/R3", i),
          wake_flag, VECS[i].ef);
      chk($sformatf("R8 vec%0d local_src", i), local_src, VECS[i].es);
    end

    // R5 exact pull timing
    clear_all();
    wake_pin = 1'b0; cyc(4);
    chk("R5 pull before filter", pull_up_sel, 1'b1);
    cyc(1);
    chk("R5 pull after filter", pull_up_sel, 1'b0);
    wake_pin = 1'b1; cyc(8);
    chk("R5 pull back high", pull_up_sel, 1'b1);

    // R6 detection disabled
    clear_all();
    lp_active = 1'b0;
    bus_dom = 1'b1; cyc(4); bus_dom = 1'b0; cyc(4); bus_dom = 1'b1; cyc(4); bus_dom = 1'b0;
    wake_pin = 1'b0; cyc(6);
    chk("R6 pull tracks while inactive", pull_up_sel, 1'b0);
    wake_pin = 1'b1; cyc(8);
    chk("R6 no wake while inactive", wake_flag, 1'b0);
    chk("R6 no source while inactive", local_src, 1'b0);
    lp_active = 1'b1;

    // R7 clear wins over a colliding wake; R8 source unaffected
    clear_all();
    clr_nrm_entry = 1'b1;
    wake_pin = 1'b0; cyc(8);
    clr_nrm_entry = 1'b0; cyc(1);
    chk("R7 clear beats set", wake_flag, 1'b0);
    chk("R8 source set by local wake", local_src, 1'b1);
    clr_nrm_exit = 1'b1; cyc(1); clr_nrm_exit = 1'b0; cyc(1);
    chk("R8 source cleared on exit", local_src, 1'b0);
    wake_pin = 1'b1; cyc(8);

    // R7 undervoltage clear
    clear_all();
    wake_pin = 1'b0; cyc(8);
    chk("R7 flag set before uv", wake_flag, 1'b1);
    uv_detect = 1'b1; cyc(1); uv_detect = 1'b0;
    chk("R7 uv clears flag", wake_flag, 1'b0);
    chk("R8 uv keeps source", local_src, 1'b1);
    wake_pin = 1'b1; cyc(8);

    // R10 held timebase, then exact wake timing
    clear_all();
    tick = 1'b0;
    wake_pin = 1'b0; cyc(10);
    chk("R10 pull frozen without tick", pull_up_sel, 1'b1);
    chk("R10 no wake without tick", wake_flag, 1'b0);
    tick = 1'b1; cyc(5);
    chk("R10 flag not yet", wake_flag, 1'b0);
    cyc(1);
    chk("R10 flag after ticks", wake_flag, 1'b1);
    wake_pin = 1'b1; cyc(8);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule